// File: doc/BRIEF.md
# Serial Flash Status Register Protection Controller

This block is the slave-side front end of a serial flash status register. It watches an SPI mode-0 byte stream (chip select low-active, serial clock, serial data in) together with a write-protect pin. All of these are brought into the system clock domain through a short synchronizer. Four commands are decoded: set the write-enable latch, clear it, stream the status register out, and write the status register. The 8-bit status register holds a busy flag, the write-enable latch, four block-protect bits, a quad-enable bit and a status-lock bit.

A status write is accepted only when the latch was set by an earlier complete frame and the block is not in hardware protected mode. Hardware protected mode needs the lock bit at 1, the write-protect pin low and quad mode off. An accepted write starts a self-timed busy period of a parameterised number of clock cycles. When that period ends, the new protection bits are committed and both the busy flag and the latch drop. Any frame whose chip select rises off a byte boundary, or that carries the wrong number of bytes, is thrown away. The block drives a mode output that tells whether hardware protection is active.

Top module: `sreg_guard`

## Requirements
- R1: After reset the status register reads 0x00, `sdo` is 0 and `hwMode` is 0.
- R2: A complete 8-bit frame with opcode 0x06 sets status bit 1 (the write-enable latch). A complete 8-bit frame with opcode 0x04 clears it. An unknown opcode changes nothing. Bits are sampled on rising `sclk`, MSB first.
- R3: Opcode 0x05 makes `sdo` shift out the status register MSB first, one bit per `sclk` rising edge, starting at the edge after the opcode. The byte repeats for as long as chip select stays low, and this works while a write cycle is running.
- R4: Opcode 0x01 followed by one data byte, with the latch set, starts a write cycle. Status bit 0 reads 1 for WRITE_CYCLES clocks. After that, bits 7:2 take data bits 7:2, and bits 1:0 both read 0. Data bits 1:0 are never stored.
- R5: A status write with the latch at 0 changes nothing.
- R6: A frame whose chip select rises after a bit count that is not a multiple of 8, or whose byte count does not fit its command (for example 0x06 or 0x04 followed by a second byte), is discarded with no change.
- R7: `hwMode` is 1 when status bit 7 is 1, `wpN` is low and status bit 6 is 0. In that state a status write is refused. Driving `wpN` high leaves the mode and allows writes again.
- R8: With status bit 6 (quad enable) at 1, `hwMode` stays 0 whatever the pin does, and status writes are accepted.
- R9: While status bit 0 is 1, opcodes 0x06, 0x04 and 0x01 are ignored.

Top module port list follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock, mode 0 |
| sdi | input | 1 | Serial data in |
| wpN | input | 1 | Write-protect pin, active low |
| sdo | output | 1 | Serial data out (status read) |
| statusOut | output | 8 | Current status register |
| hwMode | output | 1 | 1 when hardware protected mode is active |

## Verification
The serial inputs pass through two synchronizer flops and an edge detector. A chip-select rise therefore takes effect on the third clock edge after it is driven, and a latch change or the busy flag shows on `statusOut` by then. The busy flag clears about WRITE_CYCLES clocks after that. The bench allows five clocks of settling after each frame before it samples `statusOut`. It samples `sdo` just before it raises `sclk`, ten clocks after the previous rising edge. Each table vector then waits WRITE_CYCLES plus 20 clocks before it compares. The busy-length check samples 20 clocks before the nominal end and 10 clocks after it, so the three-clock synchronizer offset cannot flip either result.

// File: rtl/sreg_guard_pkg.sv
package sreg_guard_pkg;
  localparam logic [7:0] OP_SET_WEL = 8'h06;
  localparam logic [7:0] OP_CLR_WEL = 8'h04;
  localparam logic [7:0] OP_READ_SR = 8'h05;
  localparam logic [7:0] OP_WRITE_SR = 8'h01;

  localparam int BIT_BUSY = 0;
  localparam int BIT_WEL  = 1;
  localparam int BIT_QUAD = 6;
  localparam int BIT_LOCK = 7;

  typedef struct packed {
    logic setWel;
    logic clrWel;
    logic startBusy;
    logic endBusy;
    logic capData;
    logic loadOut;
    logic readMode;
  } strobe_t;

  typedef enum logic [2:0] {
    ST_OPCODE,
    ST_ARGS,
    ST_DATA,
    ST_READ,
    ST_SKIP
  } ctl_state_t;
endpackage

// File: rtl/sreg_guard_datapath.sv
module sreg_guard_datapath
  import sreg_guard_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       sclk,
  input  logic       sdi,
  input  logic       wpN,
  input  strobe_t    strb,
  output logic [7:0] rxByte,
  output logic       byteValid,
  output logic       frameEnd,
  output logic       aligned,
  output logic [7:0] statReg,
  output logic       hwMode,
  output logic       sdo
);
  localparam int LAST = SYNC_STAGES - 1;
  localparam logic [3:0] SYNC_RST = 4'b1001; // {wp, sdi, sclk, cs}

  logic [3:0] syncPipe [SYNC_STAGES];
  logic       csS, sclkS, sdiS, wpS;
  logic       csPrev, sclkPrev;
  logic       sclkRise;
  logic [2:0] bitCnt;
  logic [6:0] shiftIn;
  logic [7:0] pendData;
  logic [7:0] outShift;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SYNC_STAGES; i++) syncPipe[i] <= SYNC_RST;
    end else begin
      syncPipe[0] <= {wpN, sdi, sclk, csN};
      for (int i = 1; i < SYNC_STAGES; i++) syncPipe[i] <= syncPipe[i-1];
    end
  end

  assign {wpS, sdiS, sclkS, csS} = syncPipe[LAST];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csPrev   <= 1'b1;
      sclkPrev <= 1'b0;
    end else begin
      csPrev   <= csS;
      sclkPrev <= sclkS;
    end
  end

  assign sclkRise  = sclkS & ~sclkPrev & ~csS;
  assign frameEnd  = csS & ~csPrev;
  assign aligned   = (bitCnt == 3'd0);
  assign byteValid = sclkRise && (bitCnt == 3'd7);
  assign rxByte    = {shiftIn, sdiS};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt  <= '0;
      shiftIn <= '0;
    end else if (csS) begin
      bitCnt  <= '0;
    end else if (sclkRise) begin
      bitCnt  <= bitCnt + 3'd1;
      shiftIn <= {shiftIn[5:0], sdiS};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pendData <= '0;
    else if (strb.capData) pendData <= rxByte;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statReg <= '0;
    end else if (strb.endBusy) begin
      statReg <= {pendData[7:2], 2'b00};
    end else begin
      if (strb.startBusy) statReg[BIT_BUSY] <= 1'b1;
      if (strb.setWel)    statReg[BIT_WEL]  <= 1'b1;
      else if (strb.clrWel) statReg[BIT_WEL] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outShift <= '0;
    else if (strb.loadOut) outShift <= statReg;
    else if (sclkRise && strb.readMode) outShift <= {outShift[6:0], 1'b0};
  end

  assign sdo    = strb.readMode & outShift[7];
  assign hwMode = statReg[BIT_LOCK] & ~wpS & ~statReg[BIT_QUAD];
endmodule

// File: rtl/sreg_guard_ctrl.sv
module sreg_guard_ctrl
  import sreg_guard_pkg::*;
#(
  parameter int WRITE_CYCLES = 1000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] rxByte,
  input  logic       byteValid,
  input  logic       frameEnd,
  input  logic       aligned,
  input  logic       busy,
  input  logic       wel,
  input  logic       hwMode,
  output strobe_t    strb
);
  localparam int CW = $clog2(WRITE_CYCLES + 1);
  localparam logic [CW-1:0] LAST_CNT = CW'(WRITE_CYCLES - 1);

  ctl_state_t state, nextState;
  logic [7:0] opReg;
  logic [CW-1:0] busyCnt;

  always_comb begin
    strb = '0;
    strb.readMode = (state == ST_READ);
    strb.endBusy  = busy && (busyCnt == LAST_CNT);
    nextState = state;
    if (frameEnd) begin
      nextState = ST_OPCODE;
      if (aligned) begin
        case (state)
          ST_ARGS: begin
            if (opReg == OP_SET_WEL) strb.setWel = 1'b1;
            if (opReg == OP_CLR_WEL) strb.clrWel = 1'b1;
          end
          ST_DATA: if (wel && !hwMode) strb.startBusy = 1'b1;
          default: ;
        endcase
      end
    end else if (byteValid) begin
      case (state)
        ST_OPCODE: begin
          if (rxByte == OP_READ_SR) begin
            strb.loadOut = 1'b1;
            nextState = ST_READ;
          end else if (busy) begin
            nextState = ST_SKIP;
          end else if (rxByte == OP_SET_WEL || rxByte == OP_CLR_WEL ||
                       rxByte == OP_WRITE_SR) begin
            nextState = ST_ARGS;
          end else begin
            nextState = ST_SKIP;
          end
        end
        ST_ARGS: begin
          if (opReg == OP_WRITE_SR) begin
            strb.capData = 1'b1;
            nextState = ST_DATA;
          end else begin
            nextState = ST_SKIP;
          end
        end
        ST_DATA: nextState = ST_SKIP;
        ST_READ: strb.loadOut = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_OPCODE;
      opReg <= '0;
    end else begin
      state <= nextState;
      if (byteValid && state == ST_OPCODE) opReg <= rxByte;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busyCnt <= '0;
    else if (strb.startBusy) busyCnt <= '0;
    else if (busy) busyCnt <= busyCnt + 1'b1;
  end
endmodule

// File: rtl/sreg_guard.sv
module sreg_guard
  import sreg_guard_pkg::*;
#(
  parameter int WRITE_CYCLES = 1000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       sclk,
  input  logic       sdi,
  input  logic       wpN,
  output logic       sdo,
  output logic [7:0] statusOut,
  output logic       hwMode
);
  strobe_t    strb;
  logic [7:0] rxByte;
  logic       byteValid, frameEnd, aligned;

  sreg_guard_datapath #(.SYNC_STAGES(SYNC_STAGES)) dp_i (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdi(sdi), .wpN(wpN),
    .strb(strb), .rxByte(rxByte), .byteValid(byteValid), .frameEnd(frameEnd),
    .aligned(aligned), .statReg(statusOut), .hwMode(hwMode), .sdo(sdo)
  );

  sreg_guard_ctrl #(.WRITE_CYCLES(WRITE_CYCLES)) ctl_i (
    .clk(clk), .rstN(rstN), .rxByte(rxByte), .byteValid(byteValid),
    .frameEnd(frameEnd), .aligned(aligned), .busy(statusOut[BIT_BUSY]),
    .wel(statusOut[BIT_WEL]), .hwMode(hwMode), .strb(strb)
  );
endmodule

// File: rtl/sreg_guard_chk.sv
module sreg_guard_chk (
  input logic       clk,
  input logic       rstN,
  input logic [7:0] statusOut,
  input logic       hwMode
);
  // R4
  wel_drop_at_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(statusOut[0]) |-> !statusOut[1]);

  // R5
  busy_needs_wel_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusOut[0]) |-> $past(statusOut[1]));

  // R7
  hw_refuses_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusOut[0]) |-> !$past(hwMode));

  // R4
  commit_at_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(statusOut[7:2]) |-> $fell(statusOut[0]));

  // R8
  quad_disables_hw_chk: assert property (@(posedge clk) disable iff (!rstN)
    statusOut[6] |-> !hwMode);

  // R9
  wel_frozen_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusOut[0] && $past(statusOut[0])) |-> $stable(statusOut[1]));
endmodule

bind sreg_guard sreg_guard_chk chk_i (
  .clk(clk), .rstN(rstN), .statusOut(statusOut), .hwMode(hwMode)
);

// File: tb/sreg_guard_tb_top.sv
`timescale 1ns/1ps
module sreg_guard_tb_top;
  localparam int WCYC = 400;
  localparam int NVEC = 18;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, sclk = 1'b0, sdi = 1'b0, wpN = 1'b1;
  logic sdo, hwMode;
  logic [7:0] statusOut;
  int nChk = 0;
  int nFail = 0;

  always #2.5 clk = ~clk;

  sreg_guard #(.WRITE_CYCLES(WCYC)) dut_i (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdi(sdi), .wpN(wpN),
    .sdo(sdo), .statusOut(statusOut), .hwMode(hwMode)
  );

  // {req[33:30], op[29:22], data[21:14], nbits[13:9], wp[8], expected[7:0]}
  localparam logic [33:0] VEC [NVEC] = '{
    {4'd2, 8'h06, 8'h00, 5'd8,  1'b1, 8'h02}, // R2 set latch
    {4'd2, 8'h04, 8'h00, 5'd8,  1'b1, 8'h00}, // R2 clear latch
    {4'd5, 8'h01, 8'h3C, 5'd16, 1'b1, 8'h00}, // R5 no latch
    {4'd2, 8'h06, 8'h00, 5'd8,  1'b1, 8'h02}, // R2
    {4'd4, 8'h01, 8'hBF, 5'd16, 1'b1, 8'hBC}, // R4 low bits dropped
    {4'd6, 8'h06, 8'h00, 5'd9,  1'b1, 8'hBC}, // R6 nine bits
    {4'd2, 8'h06, 8'h00, 5'd8,  1'b1, 8'hBE}, // R2
    {4'd6, 8'h01, 8'h00, 5'd12, 1'b1, 8'hBE}, // R6 twelve bits
    {4'd7, 8'h01, 8'h00, 5'd16, 1'b0, 8'hBE}, // R7 refused
    {4'd7, 8'h01, 8'h80, 5'd16, 1'b1, 8'h80}, // R7 pin high
    {4'd2, 8'h06, 8'h00, 5'd8,  1'b0, 8'h82}, // R2 latch in hw mode
    {4'd7, 8'h01, 8'hC0, 5'd16, 1'b0, 8'h82}, // R7 refused
    {4'd7, 8'h01, 8'hC0, 5'd16, 1'b1, 8'hC0}, // R7 accepted
    {4'd2, 8'h06, 8'h00, 5'd8,  1'b0, 8'hC2}, // R2
    {4'd8, 8'h01, 8'h40, 5'd16, 1'b0, 8'h40}, // R8 quad overrides pin
    {4'd2, 8'h02, 8'h00, 5'd8,  1'b1, 8'h40}, // R2 unknown opcode
    {4'd2, 8'h06, 8'h00, 5'd8,  1'b1, 8'h42}, // R2
    {4'd6, 8'h04, 8'h00, 5'd16, 1'b1, 8'h42}  // R6 extra byte
  };

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sendBits(input logic [15:0] bits, input int n);
    csN = 1'b0;
    tick(5);
    for (int i = 0; i < n; i++) begin
      sdi = bits[15-i];
      tick(5);
      sclk = 1'b1;
      tick(5);
      sclk = 1'b0;
    end
    tick(5);
    csN = 1'b1;
    tick(5);
  endtask

  task automatic readStatus(output logic [7:0] b1, output logic [7:0] b2);
    logic [15:0] got;
    csN = 1'b0;
    tick(5);
    for (int i = 0; i < 8; i++) begin
      sdi = 8'h05 >> (7 - i);
      tick(5);
      sclk = 1'b1;
      tick(5);
      sclk = 1'b0;
    end
    for (int i = 0; i < 16; i++) begin
      sdi = 1'b0;
      tick(5);
      got[15-i] = sdo;
      sclk = 1'b1;
      tick(5);
      sclk = 1'b0;
    end
    tick(5);
    csN = 1'b1;
    tick(5);
    b1 = got[15:8];
    b2 = got[7:0];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    logic [7:0] r1, r2;
    tick(3);
    rstN = 1'b1;
    tick(3);
    check("R1 status", statusOut, 8'h00);
    check("R1 sdo", sdo, 1'b0);
    check("R1 hwMode", hwMode, 1'b0);

    for (int v = 0; v < NVEC; v++) begin
      wpN = VEC[v][8];
      tick(5);
      sendBits({VEC[v][29:22], VEC[v][21:14]}, int'(VEC[v][13:9]));
      tick(WCYC + 20);
      check($sformatf("R%0d vector %0d", VEC[v][33:30], v), statusOut, VEC[v][7:0]);
    end

    // R3 repeated read at idle
    readStatus(r1, r2);
    check("R3 first byte", r1, 8'h42);
    check("R3 second byte", r2, 8'h42);

    // R9 and R3: commands and reads during a write cycle
    wpN = 1'b1;
    tick(5);
    sendBits({8'h01, 8'h84}, 16);
    check("R4 busy set", statusOut[0], 1'b1);
    sendBits({8'h04, 8'h00}, 8);
    readStatus(r1, r2);
    check("R3 read while busy", r1, 8'h43);
    check("R9 clear ignored while busy", r2, 8'h43);
    tick(WCYC);
    check("R9 commit and latch cleared", statusOut, 8'h84);

    // R7 mode output follows pin
    wpN = 1'b0;
    tick(10);
    check("R7 hwMode on", hwMode, 1'b1);
    wpN = 1'b1;
    tick(10);
    check("R7 hwMode off", hwMode, 1'b0);

    // R4 busy length
    sendBits({8'h06, 8'h00}, 8);
    sendBits({8'h01, 8'h00}, 16);
    tick(WCYC - 20);
    check("R4 busy near end", statusOut[0], 1'b1);
    tick(30);
    check("R4 busy over", statusOut, 8'h00);

    // R1 reset mid-run
    sendBits({8'h06, 8'h00}, 8);
    rstN = 1'b0;
    tick(2);
    rstN = 1'b1;
    tick(2);
    check("R1 reset clears", statusOut, 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule